// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block decides, once per timekeeping update, whether each of two alarm settings agrees with the running clock. The clock presents four time fields: seconds, minutes, hours and day of week. Each alarm supplies one setting byte for each of those fields. The top bit of a setting byte is a mask. When the mask is set, that field is left out of the comparison. The lower bits hold the value that the field must equal.

The mask patterns give repeat rates from once per update (every field masked) to once per week (no field masked). When an alarm qualifies during an update strobe, the block emits a one-cycle set pulse for that alarm. A separate status flag register takes this pulse. Counting time, BCD rollover and flag storage live outside this block.

Top module: `masked_alarm_cmp`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, both bits of `alarm_set` are 0.
- R2: When `upd_stb` is 0 at a clock edge, `alarm_set` is 0 in the following cycle, whatever the time and alarm inputs are.
- R3: A qualifying strobe at one clock edge raises `alarm_set[i]` for exactly the next cycle. The output is 0 again in the cycle after that, as long as no new strobe arrives.
- R4: An alarm whose four mask bits are all 1 fires on every strobe, whatever its value bits and the time are.
- R5: Field index 0 is seconds, 1 is minutes, 2 is hours and 3 is day. Bit 7 of an alarm field is its mask. Bits 6:0 are compared with the 7-bit time field. An unmasked field whose bits 6:0 differ from the time field blocks the alarm. A masked field never blocks the alarm, whatever its value bits are.
- R6: With only seconds unmasked, the alarm fires exactly when the seconds are equal.
- R7: With seconds and minutes unmasked, both must be equal for the alarm to fire.
- R8: With seconds, minutes and hours unmasked, all three must be equal for the alarm to fire.
- R9: With no field masked, day, hours, minutes and seconds must all be equal for the alarm to fire.
- R10: Mask patterns outside the listed ones follow the same rule: every unmasked field must be equal. One example is seconds masked while minutes are unmasked.
- R11: The two alarms are evaluated independently. `alarm_set[0]` depends only on alarm 0's setting and `alarm_set[1]` depends only on alarm 1's setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle strobe marking a time update |
| cur_time | input | 4x7 | Current time fields, index 0 seconds up to index 3 day |
| alarm_cfg | input | 2x4x8 | Per alarm and per field: mask in bit 7, value in bits 6:0 |
| alarm_set | output | 2 | One-cycle set pulse per alarm |

## Verification
The checker assumes that `upd_stb` never stays high on two edges in a row, because the clock update is a single pulse. The single-cycle pulse property depends on this assumption. It also assumes that the time and alarm inputs are stable around the strobing edge. The stimulus drives every input on the falling edge and raises the strobe for exactly one cycle, with idle cycles between strobes. The vectors cover every mask pattern that the requirements name, including masked fields whose value bits disagree with the time and time fields at their largest 7-bit value.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int FLD_W   = 7;
    localparam int NUM_FLD = 4;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } fld_idx_e;

    typedef struct packed {
        logic             ignore;
        logic [FLD_W-1:0] value;
    } alm_fld_t;

    function automatic logic fld_agrees(alm_fld_t setting, logic [FLD_W-1:0] now);
        return setting.ignore || (setting.value == now);
    endfunction

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
    import alm_pkg::*;
(
    input  alm_fld_t         setting,
    input  logic [FLD_W-1:0] now,
    output logic             agrees
);

    always_comb begin
        agrees = fld_agrees(setting, now);
    end

endmodule

// File: rtl/alm_match_unit.sv
module alm_match_unit
    import alm_pkg::*;
(
    input  logic [NUM_FLD-1:0][FLD_W:0]   setting,
    input  logic [NUM_FLD-1:0][FLD_W-1:0] now,
    output logic                          hit
);

    logic [NUM_FLD-1:0] fld_ok;

    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
        alm_fld_t cfg;
        assign cfg = alm_fld_t'(setting[f]);
        alm_field_cmp u_cmp (
            .setting (cfg),
            .now     (now[f]),
            .agrees  (fld_ok[f])
        );
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/masked_alarm_cmp.sv
module masked_alarm_cmp
    import alm_pkg::*;
#(
    parameter int NUM_ALM = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                upd_stb,
    input  logic [NUM_FLD-1:0][FLD_W-1:0]       cur_time,
    input  logic [NUM_ALM-1:0][NUM_FLD-1:0][FLD_W:0] alarm_cfg,
    output logic [NUM_ALM-1:0]                  alarm_set
);

    logic [NUM_ALM-1:0] hit;
    logic [NUM_ALM-1:0] set_q;

    for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
        alm_match_unit u_unit (
            .setting (alarm_cfg[a]),
            .now     (cur_time),
            .hit     (hit[a])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
        end else if (upd_stb) begin
            set_q <= hit;
        end else begin
            set_q <= '0;
        end
    end

    assign alarm_set = set_q;

endmodule

// File: rtl/alm_chk.sv
module alm_chk
    import alm_pkg::*;
#(
    parameter int NUM_ALM = 2
) (
    input logic                                     clk,
    input logic                                     rst,
    input logic                                     upd_stb,
    input logic [NUM_FLD-1:0][FLD_W-1:0]            cur_time,
    input logic [NUM_ALM-1:0][NUM_FLD-1:0][FLD_W:0] alarm_cfg,
    input logic [NUM_ALM-1:0]                       alarm_set
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (alarm_set == '0));

    assert_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |=> (alarm_set == '0));

    // input assumption: the update strobe is a single-cycle pulse
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

    for (genvar a = 0; a < NUM_ALM; a++) begin : g_a
        assert_pulse_short_R3: assert property (@(posedge clk) disable iff (rst)
            alarm_set[a] |=> !alarm_set[a]);

        assert_all_masked_R4: assert property (@(posedge clk) disable iff (rst)
            (upd_stb && alarm_cfg[a][0][FLD_W] && alarm_cfg[a][1][FLD_W]
                     && alarm_cfg[a][2][FLD_W] && alarm_cfg[a][3][FLD_W])
            |=> alarm_set[a]);

        for (genvar f = 0; f < NUM_FLD; f++) begin : g_f
            assert_unmasked_miss_R5: assert property (@(posedge clk) disable iff (rst)
                (upd_stb && !alarm_cfg[a][f][FLD_W]
                         && (alarm_cfg[a][f][FLD_W-1:0] != cur_time[f]))
                |=> !alarm_set[a]);
        end
    end

endmodule

bind masked_alarm_cmp alm_chk #(.NUM_ALM(NUM_ALM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_stb   (upd_stb),
    .cur_time  (cur_time),
    .alarm_cfg (alarm_cfg),
    .alarm_set (alarm_set)
);

// File: tb/masked_alarm_cmp_test.sv
module masked_alarm_cmp_test;
    import alm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef logic [NUM_FLD-1:0][FLD_W-1:0] time_t;
    typedef logic [NUM_FLD-1:0][FLD_W:0]   cfg_t;

    typedef struct packed {
        time_t      t;
        cfg_t       a0;
        cfg_t       a1;
        logic [1:0] exp;
    } vec_t;

    function automatic time_t tm(int d, int h, int m, int s);
        return {7'(d), 7'(h), 7'(m), 7'(s)};
    endfunction

    function automatic cfg_t al(bit md, int d, bit mh, int h, bit mm, int m, bit ms, int s);
        return {md, 7'(d), mh, 7'(h), mm, 7'(m), ms, 7'(s)};
    endfunction

    // exp bit 0 = alarm 0, bit 1 = alarm 1
    localparam vec_t VECS [NV] = '{
        '{tm(1,2,3,4), al(1,0,1,0,1,0,1,0),     al(1,9,1,9,1,9,1,9),     2'b11}, // R4
        '{tm(1,2,3,4), al(1,0,1,0,1,0,0,4),     al(1,0,1,0,1,0,0,5),     2'b01}, // R6 R11
        '{tm(1,2,3,4), al(1,0,1,0,0,3,0,4),     al(1,0,1,0,0,4,0,4),     2'b01}, // R7
        '{tm(1,2,3,4), al(1,0,0,2,0,3,0,4),     al(1,0,0,9,0,3,0,4),     2'b01}, // R8
        '{tm(5,2,3,4), al(0,5,0,2,0,3,0,4),     al(0,6,0,2,0,3,0,4),     2'b01}, // R9
        '{tm(5,2,3,4), al(1,127,1,127,1,127,1,127), al(1,99,1,88,1,77,0,4), 2'b11}, // R5
        '{tm(5,2,3,4), al(1,0,1,0,0,3,1,50),    al(1,0,1,0,0,8,1,4),     2'b01}, // R10
        '{tm(5,2,3,4), al(1,0,1,0,1,0,0,9),     al(0,5,0,2,0,3,0,4),     2'b10}, // R11
        '{tm(127,127,127,127), al(0,127,0,127,0,127,0,127), al(1,0,0,0,1,0,1,0), 2'b01}, // R9 R5
        '{tm(0,0,0,0), al(0,1,1,0,1,0,1,0),     al(1,0,1,0,0,1,0,0),     2'b00}  // R10
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_stb = 1'b0;
    time_t cur_time = '0;
    logic [1:0][NUM_FLD-1:0][FLD_W:0] alarm_cfg = '0;
    logic [1:0] alarm_set;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_alarm_cmp #(.NUM_ALM(2)) uut (
        .clk       (clk),
        .rst       (rst),
        .upd_stb   (upd_stb),
        .cur_time  (cur_time),
        .alarm_cfg (alarm_cfg),
        .alarm_set (alarm_set)
    );

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: alarm_set=%b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse_and_check(string req, logic [1:0] exp);
        @(negedge clk);
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        check(req, alarm_set, exp);
        @(negedge clk);
        check("R3 pulse ends", alarm_set, 2'b00);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", alarm_set, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", alarm_set, 2'b00);

        for (int i = 0; i < NV; i++) begin
            cur_time     = VECS[i].t;
            alarm_cfg[0] = VECS[i].a0;
            alarm_cfg[1] = VECS[i].a1;
            pulse_and_check($sformatf("vector %0d R5 R6 R7 R8 R9 R10 R11", i), VECS[i].exp);
        end

        // R2: both alarms match but no strobe
        cur_time     = tm(3,4,5,6);
        alarm_cfg[0] = al(0,3,0,4,0,5,0,6);
        alarm_cfg[1] = al(1,0,1,0,1,0,1,0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R2 no strobe", alarm_set, 2'b00);
        end

        // R3: a strobe with a match gives exactly one cycle high
        pulse_and_check("R3 one pulse", 2'b11);

        // R4: all masked fires on successive strobes while time advances
        for (int s = 0; s < 3; s++) begin
            cur_time = tm(0,0,0,s+10);
            alarm_cfg[0] = al(1,1,1,2,1,3,1,4);
            alarm_cfg[1] = al(1,0,1,0,1,0,0,11);
            pulse_and_check("R4 every strobe", (s == 1) ? 2'b11 : 2'b01);
        end

        // R1: reset during a strobe suppresses the pulse
        @(negedge clk);
        upd_stb = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        check("R1 reset wins", alarm_set, 2'b00);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule